// File: doc/BRIEF.md
# Programmable LCD Panel Timing Generator

This block produces the horizontal and vertical timing for an LCD panel from a set of raw timing codes. It decodes each code into a count of pixel clocks or lines, counts pixels and lines, and drives a line-sync pulse, a frame-sync pulse and a display-enable window. A single select input chooses between a passive (STN) panel and an active (TFT) panel. The select changes how the horizontal display start is offset and which display-width rules apply.

The decoded timing set is held in shadow registers. It is refreshed only as a new frame begins, so a code that changes in the middle of a frame never disturbs the frame in progress. The decoded set is checked for consistency when it is captured. An inconsistent set raises `cfgError` and holds every sync and enable output low for that frame, while the counters keep running.

Top module: `panel_timing_gen`

## Requirements
- R1: While reset is asserted (`rst_n` low), `pixCount` and `lineCount` read 0 and `lineSync`, `frameSync`, `dispEn` and `cfgError` are all 0.
- R2: The line length in pixel clocks is HT = (`hTotalCode` + 1) × 8. `pixCount` steps by one per clock from 0 to HT−1 and then returns to 0.
- R3: The frame length in lines is VT = `vTotalCode` + 1. `lineCount` steps by one in the cycle where `pixCount` returns to 0, and goes from VT−1 back to 0.
- R4: The horizontal start is HS = `hStartCode` + 22 when `panelTft` = 0 and HS = `hStartCode` + 5 when `panelTft` = 1. The horizontal width is HD = (`hDispCode` + 1) × 8. The vertical start is VS = `vStartCode` and the vertical height is VD = `vDispCode` + 1. `dispEn` is 1 exactly when HS ≤ `pixCount` < HS+HD and VS ≤ `lineCount` < VS+VD.
- R5: `lineSync` is 1 exactly when P ≤ `pixCount` < P+W, where P = `lineSyncPosCode` + 1 and W = `lineSyncWidthCode` + 1. The pulse is cut short at the end of the line and does not wrap.
- R6: `frameSync` is 1 for every pixel of the lines with Q ≤ `lineCount` < Q+L, where Q = `frameSyncPosCode` and L = `frameSyncWidthCode` + 1.
- R7: `cfgError` is 1 when HS+HD ≥ HT or VS+VD ≥ VT. While it is 1, `lineSync`, `frameSync` and `dispEn` stay 0.
- R8: When `panelTft` = 0, `cfgError` is also 1 if HD < 32 or HD is not a multiple of 16. When `panelTft` = 1, any HD is accepted by this rule.
- R9: The input codes and `panelTft` are captured on the first clock edge after reset is released, which shows `pixCount` = `lineCount` = 0. They are captured again on each edge that returns both counters to 0. Input changes at any other time have no effect on the outputs until the next such capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| panelTft | input | 1 | Panel type: 0 passive STN, 1 active TFT |
| hTotalCode | input | 7 | Line length code |
| hDispCode | input | 7 | Horizontal display width code |
| hStartCode | input | 10 | Horizontal display start code |
| lineSyncPosCode | input | 10 | Line-sync start code |
| lineSyncWidthCode | input | 7 | Line-sync width code |
| vTotalCode | input | 10 | Frame length code |
| vDispCode | input | 10 | Vertical display height code |
| vStartCode | input | 10 | Vertical display start code |
| frameSyncPosCode | input | 10 | Frame-sync start line code |
| frameSyncWidthCode | input | 7 | Frame-sync width code |
| lineSync | output | 1 | Line-sync pulse, active high |
| frameSync | output | 1 | Frame-sync pulse, active high |
| dispEn | output | 1 | Active display window |
| cfgError | output | 1 | Captured timing set is inconsistent |
| pixCount | output | 11 | Pixel position within the line |
| lineCount | output | 11 | Line position within the frame |

## Verification
The counters are visible on the ports, so a counter that slips or wraps at the wrong total shows up on `pixCount` or `lineCount` within one cycle. The windows derive from those counters through a fixed offset. A wrong decode offset or a wrong window bound therefore appears on `dispEn`, `lineSync` or `frameSync` within the first line that crosses the bound. A shadow register that captures at the wrong time shows as outputs that follow a mid-frame code change before the frame ends, or as `cfgError` toggling anywhere other than at counter position (0,0). A capture that comes too late shows as a frame that starts with stale values.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  localparam int TOT_CODE_W    = 7;
  localparam int POS_CODE_W    = 10;
  localparam int WID_CODE_W    = 7;
  localparam int SCALE_SH      = 3;
  localparam int STN_OFS       = 22;
  localparam int TFT_OFS       = 5;
  localparam int STN_MIN_DISP  = 32;
  localparam int STN_DISP_STEP = 16;
  localparam int H_MAX         = (1 << TOT_CODE_W) << SCALE_SH;
  localparam int P_MAX         = (1 << POS_CODE_W) + STN_OFS;
  localparam int CNT_W         = $clog2(((H_MAX > P_MAX) ? H_MAX : P_MAX) + 1);
  localparam int SUM_W         = CNT_W + 1;
  localparam int STEP_BITS     = $clog2(STN_DISP_STEP);

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t hTotal;
    cnt_t hDisp;
    cnt_t hStart;
    cnt_t lpStart;
    cnt_t lpWidth;
    cnt_t vTotal;
    cnt_t vDisp;
    cnt_t vStart;
    cnt_t fpStart;
    cnt_t fpWidth;
  } timing_t;

  typedef struct packed {
    logic loadShadow;
    logic running;
  } strobe_t;
endpackage

// File: rtl/ptg_decode.sv
module ptg_decode
  import ptg_pkg::*;
(
  input  logic                  panelTft,
  input  logic [TOT_CODE_W-1:0] hTotalCode,
  input  logic [TOT_CODE_W-1:0] hDispCode,
  input  logic [POS_CODE_W-1:0] hStartCode,
  input  logic [POS_CODE_W-1:0] lineSyncPosCode,
  input  logic [WID_CODE_W-1:0] lineSyncWidthCode,
  input  logic [POS_CODE_W-1:0] vTotalCode,
  input  logic [POS_CODE_W-1:0] vDispCode,
  input  logic [POS_CODE_W-1:0] vStartCode,
  input  logic [POS_CODE_W-1:0] frameSyncPosCode,
  input  logic [WID_CODE_W-1:0] frameSyncWidthCode,
  output timing_t               dec,
  output logic                  decErr
);
  logic [SUM_W-1:0] hEndSum, vEndSum;
  logic hBad, vBad, stnBad;

  always_comb begin
    dec.hTotal  = (cnt_t'(hTotalCode) + cnt_t'(1)) << SCALE_SH;
    dec.hDisp   = (cnt_t'(hDispCode) + cnt_t'(1)) << SCALE_SH;
    dec.hStart  = cnt_t'(hStartCode) + (panelTft ? cnt_t'(TFT_OFS) : cnt_t'(STN_OFS));
    dec.lpStart = cnt_t'(lineSyncPosCode) + cnt_t'(1);
    dec.lpWidth = cnt_t'(lineSyncWidthCode) + cnt_t'(1);
    dec.vTotal  = cnt_t'(vTotalCode) + cnt_t'(1);
    dec.vDisp   = cnt_t'(vDispCode) + cnt_t'(1);
    dec.vStart  = cnt_t'(vStartCode);
    dec.fpStart = cnt_t'(frameSyncPosCode);
    dec.fpWidth = cnt_t'(frameSyncWidthCode) + cnt_t'(1);
  end

  // consistency rules of the decoded set
  always_comb begin
    hEndSum = {1'b0, dec.hStart} + {1'b0, dec.hDisp};
    vEndSum = {1'b0, dec.vStart} + {1'b0, dec.vDisp};
    hBad    = hEndSum >= {1'b0, dec.hTotal};
    vBad    = vEndSum >= {1'b0, dec.vTotal};
    stnBad  = !panelTft && ((dec.hDisp < cnt_t'(STN_MIN_DISP)) ||
                            (dec.hDisp[STEP_BITS-1:0] != '0));
    decErr  = hBad || vBad || stnBad;
  end
endmodule

// File: rtl/ptg_ctrl.sv
module ptg_ctrl
  import ptg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  cnt_t    hTotal,
  input  cnt_t    vTotal,
  output strobe_t stb,
  output cnt_t    hCount,
  output cnt_t    vCount
);
  logic running;
  logic hEnd, vEnd;

  always_comb begin
    hEnd           = hCount == (hTotal - cnt_t'(1));
    vEnd           = vCount == (vTotal - cnt_t'(1));
    stb.running    = running;
    stb.loadShadow = !running || (hEnd && vEnd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      hCount  <= '0;
      vCount  <= '0;
    end else if (!running) begin
      running <= 1'b1;
    end else if (hEnd) begin
      hCount <= '0;
      vCount <= vEnd ? '0 : vCount + cnt_t'(1);
    end else begin
      hCount <= hCount + cnt_t'(1);
    end
  end
endmodule

// File: rtl/ptg_datapath.sv
module ptg_datapath
  import ptg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t stb,
  input  timing_t dec,
  input  logic    decErr,
  input  cnt_t    hCount,
  input  cnt_t    vCount,
  output cnt_t    hTotal,
  output cnt_t    vTotal,
  output logic    lineSync,
  output logic    frameSync,
  output logic    dispEn,
  output logic    cfgError
);
  timing_t shadow;
  logic    shadowErr;
  logic    outOk;

  function automatic logic inWindow(cnt_t pos, cnt_t start, cnt_t len);
    logic [SUM_W-1:0] stop;
    stop = {1'b0, start} + {1'b0, len};
    return (pos >= start) && ({1'b0, pos} < stop);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow    <= '0;
      shadowErr <= 1'b0;
    end else if (stb.loadShadow) begin
      shadow    <= dec;
      shadowErr <= decErr;
    end
  end

  always_comb begin
    hTotal    = shadow.hTotal;
    vTotal    = shadow.vTotal;
    cfgError  = shadowErr;
    outOk     = stb.running && !shadowErr;
    dispEn    = outOk && inWindow(hCount, shadow.hStart, shadow.hDisp)
                      && inWindow(vCount, shadow.vStart, shadow.vDisp);
    lineSync  = outOk && inWindow(hCount, shadow.lpStart, shadow.lpWidth);
    frameSync = outOk && inWindow(vCount, shadow.fpStart, shadow.fpWidth);
  end
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
  import ptg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  panelTft,
  input  logic [TOT_CODE_W-1:0] hTotalCode,
  input  logic [TOT_CODE_W-1:0] hDispCode,
  input  logic [POS_CODE_W-1:0] hStartCode,
  input  logic [POS_CODE_W-1:0] lineSyncPosCode,
  input  logic [WID_CODE_W-1:0] lineSyncWidthCode,
  input  logic [POS_CODE_W-1:0] vTotalCode,
  input  logic [POS_CODE_W-1:0] vDispCode,
  input  logic [POS_CODE_W-1:0] vStartCode,
  input  logic [POS_CODE_W-1:0] frameSyncPosCode,
  input  logic [WID_CODE_W-1:0] frameSyncWidthCode,
  output logic                  lineSync,
  output logic                  frameSync,
  output logic                  dispEn,
  output logic                  cfgError,
  output logic [CNT_W-1:0]      pixCount,
  output logic [CNT_W-1:0]      lineCount
);
  timing_t decTiming;
  logic    decErr;
  strobe_t stb;
  cnt_t    hTotal, vTotal;

  ptg_decode u_decode (
    .panelTft(panelTft), .hTotalCode(hTotalCode), .hDispCode(hDispCode),
    .hStartCode(hStartCode), .lineSyncPosCode(lineSyncPosCode),
    .lineSyncWidthCode(lineSyncWidthCode), .vTotalCode(vTotalCode),
    .vDispCode(vDispCode), .vStartCode(vStartCode),
    .frameSyncPosCode(frameSyncPosCode), .frameSyncWidthCode(frameSyncWidthCode),
    .dec(decTiming), .decErr(decErr)
  );

  ptg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .hTotal(hTotal), .vTotal(vTotal),
    .stb(stb), .hCount(pixCount), .vCount(lineCount)
  );

  ptg_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .dec(decTiming), .decErr(decErr),
    .hCount(pixCount), .vCount(lineCount), .hTotal(hTotal), .vTotal(vTotal),
    .lineSync(lineSync), .frameSync(frameSync), .dispEn(dispEn),
    .cfgError(cfgError)
  );
endmodule

// File: rtl/ptg_checker.sv
module ptg_checker
  import ptg_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic lineSync,
  input logic frameSync,
  input logic dispEn,
  input logic cfgError,
  input cnt_t pixCount,
  input cnt_t lineCount
);
  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfgError |-> (!lineSync && !frameSync && !dispEn));

  a_r2_pix_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pixCount != '0) |-> (pixCount == $past(pixCount) + cnt_t'(1)));

  a_r3_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pixCount != '0) |-> $stable(lineCount));

  a_r6_frame_sync_line_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (pixCount != '0) |-> $stable(frameSync));

  a_r9_err_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfgError) |-> (pixCount == '0 && lineCount == '0));
endmodule

bind panel_timing_gen ptg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .lineSync(lineSync), .frameSync(frameSync),
  .dispEn(dispEn), .cfgError(cfgError), .pixCount(pixCount),
  .lineCount(lineCount)
);

// File: tb/panel_timing_gen_test.sv
`timescale 1ns/1ps
module panel_timing_gen_test;
  import ptg_pkg::*;

  typedef struct {
    bit tft;
    int htc, hdc, hsc, lpc, lwc, vtc, vdc, vsc, fpc, fwc;
  } cfg_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic panelTft;
  logic [TOT_CODE_W-1:0] hTotalCode, hDispCode;
  logic [POS_CODE_W-1:0] hStartCode, lineSyncPosCode, vTotalCode, vDispCode, vStartCode, frameSyncPosCode;
  logic [WID_CODE_W-1:0] lineSyncWidthCode, frameSyncWidthCode;
  logic lineSync, frameSync, dispEn, cfgError;
  logic [CNT_W-1:0] pixCount, lineCount;

  panel_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .panelTft(panelTft), .hTotalCode(hTotalCode),
    .hDispCode(hDispCode), .hStartCode(hStartCode), .lineSyncPosCode(lineSyncPosCode),
    .lineSyncWidthCode(lineSyncWidthCode), .vTotalCode(vTotalCode), .vDispCode(vDispCode),
    .vStartCode(vStartCode), .frameSyncPosCode(frameSyncPosCode),
    .frameSyncWidthCode(frameSyncWidthCode), .lineSync(lineSync), .frameSync(frameSync),
    .dispEn(dispEn), .cfgError(cfgError), .pixCount(pixCount), .lineCount(lineCount)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;
  cfg_t live, shad;
  bit mRun;
  int mh, mv;

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d (h=%0d v=%0d)", req, what, act, exp, mh, mv);
    end
  endtask

  task automatic drive(cfg_t c);
    live               = c;
    panelTft           = c.tft;
    hTotalCode         = TOT_CODE_W'(c.htc);
    hDispCode          = TOT_CODE_W'(c.hdc);
    hStartCode         = POS_CODE_W'(c.hsc);
    lineSyncPosCode    = POS_CODE_W'(c.lpc);
    lineSyncWidthCode  = WID_CODE_W'(c.lwc);
    vTotalCode         = POS_CODE_W'(c.vtc);
    vDispCode          = POS_CODE_W'(c.vdc);
    vStartCode         = POS_CODE_W'(c.vsc);
    frameSyncPosCode   = POS_CODE_W'(c.fpc);
    frameSyncWidthCode = WID_CODE_W'(c.fwc);
  endtask

  task automatic compare();
    int ht, hd, hs, lps, lpw, vt, vd, vs, fps, fpw;
    bit geomBad, stnBad, err, ok;
    if (!mRun) begin
      check("R1", "pixCount", int'(pixCount), 0);
      check("R1", "lineCount", int'(lineCount), 0);
      check("R1", "dispEn", int'(dispEn), 0);
      check("R1", "lineSync", int'(lineSync), 0);
      check("R1", "frameSync", int'(frameSync), 0);
      check("R1", "cfgError", int'(cfgError), 0);
    end else begin
      ht  = (shad.htc + 1) * 8;
      hd  = (shad.hdc + 1) * 8;
      hs  = shad.hsc + (shad.tft ? 5 : 22);
      lps = shad.lpc + 1;
      lpw = shad.lwc + 1;
      vt  = shad.vtc + 1;
      vd  = shad.vdc + 1;
      vs  = shad.vsc;
      fps = shad.fpc;
      fpw = shad.fwc + 1;
      geomBad = (hs + hd >= ht) || (vs + vd >= vt);
      stnBad  = !shad.tft && ((hd < 32) || (hd % 16 != 0));
      err = geomBad || stnBad;
      ok  = !err;
      check("R2", "pixCount", int'(pixCount), mh);
      check("R3", "lineCount", int'(lineCount), mv);
      if (stnBad) check("R8", "cfgError", int'(cfgError), 1);
      else        check("R7", "cfgError", int'(cfgError), int'(err));
      check("R4", "dispEn", int'(dispEn),
            int'(ok && mh >= hs && mh < hs + hd && mv >= vs && mv < vs + vd));
      check("R5", "lineSync", int'(lineSync), int'(ok && mh >= lps && mh < lps + lpw));
      check("R6", "frameSync", int'(frameSync), int'(ok && mv >= fps && mv < fps + fpw));
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (!rst_n) begin
      mRun = 0; mh = 0; mv = 0;
    end else if (!mRun) begin
      mRun = 1; mh = 0; mv = 0; shad = live;
    end else begin
      if (mh == (shad.htc + 1) * 8 - 1) begin
        mh = 0;
        if (mv == shad.vtc) begin
          mv = 0;
          shad = live;
        end else mv++;
      end else mh++;
    end
    compare();
  endtask

  task automatic restart(cfg_t c);
    drive(c);
    rst_n = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
  endtask

  task automatic runCfg(cfg_t c);
    restart(c);
    repeat (2 * (c.htc + 1) * 8 * (c.vtc + 1) + 3) cyc();
  endtask

  initial begin
    cfg_t c1, c2, c3, c4, c5, c6, c7, c8, vErr;
    c1   = '{1, 5, 3, 2, 40, 3, 5, 2, 1, 4, 0};   // TFT, clean
    c2   = '{0, 9, 5, 3, 75, 9, 4, 1, 2, 0, 1};   // STN, line pulse cut at line end
    c3   = '{0, 9, 4, 3, 75, 9, 4, 1, 2, 0, 1};   // STN width 40: R8 error
    c4   = '{1, 9, 4, 3, 75, 9, 4, 1, 2, 0, 1};   // same codes as TFT: accepted
    c5   = '{1, 5, 3, 11, 40, 3, 5, 2, 1, 4, 0};  // R7 boundary: 16+32 == 48
    c6   = '{1, 5, 3, 10, 40, 3, 5, 2, 1, 4, 0};  // R7 boundary: 15+32 == 47
    c7   = '{1, 5, 3, 2, 40, 3, 5, 2, 3, 4, 0};   // R7 vertical: 3+3 == 6
    c8   = '{0, 9, 1, 3, 75, 9, 4, 1, 2, 0, 1};   // R8: STN width 16 < 32
    vErr = c7;
    rst_n = 1'b0;
    drive(c1);
    mRun = 0; mh = 0; mv = 0;
    runCfg(c1);
    runCfg(c2);
    runCfg(c3);
    runCfg(c4);
    runCfg(c5);
    runCfg(c6);
    runCfg(c7);
    runCfg(c8);
    // R9: change codes mid-frame, effect only at next frame start
    restart(c1);
    while (!(mRun && mv == 2 && mh == 10)) cyc();
    drive(vErr);
    cyc();
    while (!(mh == 0 && mv == 0)) begin
      check("R9", "cfgError before frame start", int'(cfgError), 0);
      cyc();
    end
    check("R9", "cfgError at frame start", int'(cfgError), 1);
    repeat (300) cyc();
    drive(c2);
    repeat (400) cyc();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule